// File: doc/BRIEF.md
# Protection Fault Manager with Timed Restart

This block sits between the protection comparators of a two-stage converter (a power-factor front end followed by a resonant back end) and the two switching controllers. It watches one-cycle event strobes for overcurrent, overvoltage, feedback disconnection and soft-start timeout. It also watches level inputs for bus undervoltage and brown-out. From these it decides when each stage must stop. Overcurrent sources trip only after a programmable run of consecutive events. Overvoltage, disconnection and timeout trip on the first enabled event. Undervoltage trips after a long persistence window, or at once when it coincides with brown-out if the adaptive rule is selected.

Every shutdown begins with an early-warning pulse. If the cause is benign, the pulse is long: the front end stops and the back end keeps running until the pulse ends. If the cause is dangerous, or the burst-mode option is set, the pulse is short and both stages stop together. After the pulse, a fault that is configured to latch, or any disconnection, holds the block off until reset. Any other fault starts a retry wait whose length doubles with each step of a 2-bit code. At the end of the wait the block issues a one-cycle restart request.

Top module: `fm_fault_manager`

## Requirements
- R1: After reset, pfc_stop, llc_stop, latched, restart_req and ew_pulse are all low.
- R2: An overcurrent source trips on the event that brings its consecutive count to 1 << limit_sel (codes 0..3 give 1, 2, 4, 8). Fewer events leave both stop outputs low.
- R3: A cycle in which sw_cycle_done is high and that source's event strobe is low clears the source's count. An event that arrives in the same cycle as sw_cycle_done is counted.
- R4: An enabled overvoltage (either stage), feedback-open or soft-start-timeout strobe trips on its first occurrence. pfc_stop and llc_stop are high in the cycle after the strobe is sampled.
- R5: fault_en bit positions are 0 front-end overcurrent, 1 back-end overcurrent, 2 front-end overvoltage, 3 back-end overvoltage, 4 undervoltage, 5 feedback open, 6 soft-start timeout. A source whose bit is 0 never causes a stop.
- R6: With uv_adaptive low, undervoltage trips on the UV_PERSIST_US*CYC_PER_US-th consecutive sampled cycle of bus_uv_lvl high. Any low cycle restarts the count.
- R7: With uv_adaptive high, bus_uv_lvl and brownout_lvl high together trip on the first sampled cycle. Undervoltage without brown-out follows the R6 rule.
- R8: An undervoltage shutdown with burst_quick low gives an ew_pulse of EW_LONG_US*CYC_PER_US cycles. During the pulse pfc_stop is high and llc_stop is low. llc_stop rises when the pulse ends.
- R9: A dangerous shutdown (every source except undervoltage) gives an ew_pulse of EW_SHORT_US*CYC_PER_US cycles with both stops high from its first cycle. If a dangerous and a benign source trip in the same cycle, the dangerous handling wins.
- R10: With burst_quick high, an undervoltage shutdown uses the short pulse and stops both stages at once.
- R11: A shutdown whose tripping sources include a fault_latch_sel bit (same positions as R5), or a feedback-open trip regardless of its bit, sets latched when the pulse ends. latched and both stops then stay high and restart_req stays low until reset.
- R12: Any other shutdown holds both stops high for (RETRY_BASE_US*CYC_PER_US) << retry_sel cycles after the pulse. It then drives restart_req high for exactly one cycle, and in that same cycle both stops are low.
- R13: Event strobes and levels that arrive while pfc_stop is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_cycle_done | input | 1 | Strobe: one switching cycle completed |
| pfc_oc_hit | input | 1 | Front-end overcurrent event strobe |
| llc_oc_hit | input | 1 | Back-end overcurrent event strobe |
| pfc_ovp_hit | input | 1 | Front-end hardware overvoltage strobe |
| llc_ovp_hit | input | 1 | Back-end overvoltage strobe |
| fb_open_hit | input | 1 | Feedback disconnection strobe |
| ss_timeout_hit | input | 1 | Soft-start timeout strobe |
| bus_uv_lvl | input | 1 | Bus undervoltage level |
| brownout_lvl | input | 1 | Mains brown-out level |
| fault_en | input | 7 | Per-source enable |
| fault_latch_sel | input | 7 | Per-source latch select |
| pfc_oc_limit_sel | input | 2 | Front-end overcurrent run-length code |
| llc_oc_limit_sel | input | 2 | Back-end overcurrent run-length code |
| uv_adaptive | input | 1 | Adaptive undervoltage rule select |
| retry_sel | input | 2 | Retry wait code (doubling) |
| burst_quick | input | 1 | Force short pulse for benign shutdowns |
| pfc_stop | output | 1 | Stop front-end switching |
| llc_stop | output | 1 | Stop back-end switching |
| latched | output | 1 | Locked off until reset |
| restart_req | output | 1 | One-cycle restart request |
| ew_pulse | output | 1 | Early-warning pulse |

## Verification
Two things can land in the same cycle: a switching-cycle completion and an overcurrent event. The bench runs three events, each paired with sw_cycle_done, and then a fourth bare event. With a run length of four, that fourth event must trip. A benign and a dangerous trip can also coincide: undervoltage with brown-out is raised in the same cycle as a timeout strobe, and the bench expects the short pulse with both stops high. Every pulse length and retry wait is counted cycle by cycle at the outputs and compared with the arithmetic from the parameters.

// File: rtl/fm_pkg.sv
package fm_pkg;
   localparam int FLT_N      = 7;
   localparam int FI_PFC_OC  = 0;
   localparam int FI_LLC_OC  = 1;
   localparam int FI_PFC_OVP = 2;
   localparam int FI_LLC_OVP = 3;
   localparam int FI_UV      = 4;
   localparam int FI_FB_OPEN = 5;
   localparam int FI_SS_TO   = 6;

   // every source except undervoltage is treated as dangerous
   localparam logic [FLT_N-1:0] DANGER_MASK  = ~(FLT_N'(1) << FI_UV);
   localparam logic [FLT_N-1:0] FORCED_LATCH = FLT_N'(1) << FI_FB_OPEN;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_WARN  = 2'd1,
      ST_RETRY = 2'd2,
      ST_LOCK  = 2'd3
   } fm_state_e;
endpackage

// File: rtl/fm_event_counter.sv
module fm_event_counter #(
   parameter int MAX_LOG = 3,
   localparam int SEL_W  = $clog2(MAX_LOG + 1),
   localparam int CNT_W  = MAX_LOG + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             en,
   input  logic             hit,
   input  logic             cycle_done,
   input  logic [SEL_W-1:0] limit_sel,
   output logic             trip
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] limit;

   generate
      if (MAX_LOG < 1) begin : g_bad_max
         $error("fm_event_counter: MAX_LOG must be at least 1");
      end
   endgenerate

   always_comb begin
      limit   = CNT_W'(1) << limit_sel;
      cnt_inc = cnt_q + CNT_W'(1);
      trip    = arm && en && hit && (cnt_inc >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!arm || !en)     cnt_q <= '0;
      else if (hit)             cnt_q <= trip ? '0 : cnt_inc;
      else if (cycle_done)      cnt_q <= '0;
   end

   assert_clear_on_quiet_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && en && cycle_done && !hit) |=> (cnt_q == '0));

   assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < (CNT_W'(1) << MAX_LOG));
endmodule

// File: rtl/fm_uv_qualifier.sv
module fm_uv_qualifier #(
   parameter int PERSIST_CYC = 1000,
   localparam int CNT_W      = $clog2(PERSIST_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic en,
   input  logic uv,
   input  logic brownout,
   input  logic adaptive,
   output logic trip
);
   logic [CNT_W-1:0] cnt_q;
   logic             slow_done;

   generate
      if (PERSIST_CYC < 2) begin : g_bad_persist
         $error("fm_uv_qualifier: PERSIST_CYC must be at least 2");
      end
   endgenerate

   always_comb begin
      slow_done = (cnt_q == CNT_W'(PERSIST_CYC - 1));
      trip      = arm && en && uv && (slow_done || (adaptive && brownout));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (!(arm && en && uv))   cnt_q <= '0;
      else if (!slow_done)           cnt_q <= cnt_q + CNT_W'(1);
   end

   assert_persist_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(PERSIST_CYC - 1));

   assert_low_level_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv) |=> (cnt_q == '0));
endmodule

// File: rtl/fm_shutdown_seq.sv
module fm_shutdown_seq
   import fm_pkg::*;
#(
   parameter int EW_LONG_CYC    = 300000,
   parameter int EW_SHORT_CYC   = 16200,
   parameter int RETRY_BASE_CYC = 32760000,
   parameter int RETRY_SEL_W    = 2,
   localparam int TMR_W         = $clog2(RETRY_BASE_CYC * (1 << ((1 << RETRY_SEL_W) - 1)) + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [FLT_N-1:0]       trip_vec,
   input  logic [FLT_N-1:0]       latch_sel,
   input  logic [RETRY_SEL_W-1:0] retry_sel,
   input  logic                   burst_quick,
   output logic                   pfc_stop,
   output logic                   llc_stop,
   output logic                   latched,
   output logic                   restart_req,
   output logic                   ew_pulse
);
   fm_state_e        state_q;
   logic [TMR_W-1:0] timer_q;
   logic             quick_q;
   logic             lock_q;
   logic             restart_q;
   logic             any_trip;
   logic             quick_now;
   logic             lock_now;
   logic [TMR_W-1:0] retry_len;

   generate
      if (EW_SHORT_CYC < 1 || EW_SHORT_CYC >= EW_LONG_CYC) begin : g_bad_pulse
         $error("fm_shutdown_seq: need 1 <= EW_SHORT_CYC < EW_LONG_CYC");
      end
      if (RETRY_BASE_CYC < 1) begin : g_bad_retry
         $error("fm_shutdown_seq: RETRY_BASE_CYC must be positive");
      end
   endgenerate

   always_comb begin
      any_trip  = |trip_vec;
      quick_now = (|(trip_vec & DANGER_MASK)) || burst_quick;
      lock_now  = |(trip_vec & (latch_sel | FORCED_LATCH));
      retry_len = TMR_W'(RETRY_BASE_CYC) << retry_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         timer_q   <= '0;
         quick_q   <= 1'b0;
         lock_q    <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         restart_q <= 1'b0;
         unique case (state_q)
            ST_RUN: begin
               if (any_trip) begin
                  state_q <= ST_WARN;
                  quick_q <= quick_now;
                  lock_q  <= lock_now;
                  timer_q <= quick_now ? TMR_W'(EW_SHORT_CYC - 1) : TMR_W'(EW_LONG_CYC - 1);
               end
            end
            ST_WARN: begin
               if (timer_q == '0) begin
                  if (lock_q) begin
                     state_q <= ST_LOCK;
                  end else begin
                     state_q <= ST_RETRY;
                     timer_q <= retry_len - TMR_W'(1);
                  end
               end else begin
                  timer_q <= timer_q - TMR_W'(1);
               end
            end
            ST_RETRY: begin
               if (timer_q == '0) begin
                  state_q   <= ST_RUN;
                  restart_q <= 1'b1;
               end else begin
                  timer_q <= timer_q - TMR_W'(1);
               end
            end
            ST_LOCK: state_q <= ST_LOCK;
            default: state_q <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      ew_pulse    = (state_q == ST_WARN);
      pfc_stop    = (state_q != ST_RUN);
      llc_stop    = (state_q == ST_LOCK) || (state_q == ST_RETRY) ||
                    ((state_q == ST_WARN) && quick_q);
      latched     = (state_q == ST_LOCK);
      restart_req = restart_q;
   end

   assert_stop_enters_via_warning_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pfc_stop) |-> ew_pulse);

   assert_dangerous_stops_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ew_pulse) && $past(|(trip_vec & DANGER_MASK))) |-> llc_stop);

   assert_lock_persists_R11: assert property (@(posedge clk) disable iff (!rst_n)
      latched |=> latched);

   assert_lock_after_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latched) |-> $past(ew_pulse));

   assert_restart_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req);

   assert_restart_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> (!pfc_stop && $past(pfc_stop) && !$past(ew_pulse)));
endmodule

// File: rtl/fm_fault_manager.sv
module fm_fault_manager
   import fm_pkg::*;
#(
   parameter int CYC_PER_US    = 60,
   parameter int EW_LONG_US    = 5000,
   parameter int EW_SHORT_US   = 270,
   parameter int UV_PERSIST_US = 100000,
   parameter int RETRY_BASE_US = 546000,
   parameter int OC_MAX_LOG    = 3,
   localparam int OC_SEL_W     = $clog2(OC_MAX_LOG + 1),
   localparam int OC_SRC_N     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sw_cycle_done,
   input  logic                pfc_oc_hit,
   input  logic                llc_oc_hit,
   input  logic                pfc_ovp_hit,
   input  logic                llc_ovp_hit,
   input  logic                fb_open_hit,
   input  logic                ss_timeout_hit,
   input  logic                bus_uv_lvl,
   input  logic                brownout_lvl,
   input  logic [FLT_N-1:0]    fault_en,
   input  logic [FLT_N-1:0]    fault_latch_sel,
   input  logic [OC_SEL_W-1:0] pfc_oc_limit_sel,
   input  logic [OC_SEL_W-1:0] llc_oc_limit_sel,
   input  logic                uv_adaptive,
   input  logic [1:0]          retry_sel,
   input  logic                burst_quick,
   output logic                pfc_stop,
   output logic                llc_stop,
   output logic                latched,
   output logic                restart_req,
   output logic                ew_pulse
);
   localparam int EW_LONG_CYC    = EW_LONG_US * CYC_PER_US;
   localparam int EW_SHORT_CYC   = EW_SHORT_US * CYC_PER_US;
   localparam int UV_PERSIST_CYC = UV_PERSIST_US * CYC_PER_US;
   localparam int RETRY_BASE_CYC = RETRY_BASE_US * CYC_PER_US;

   generate
      if (CYC_PER_US < 1) begin : g_bad_clk
         $error("fm_fault_manager: CYC_PER_US must be positive");
      end
   endgenerate

   logic                       armed;
   logic [FLT_N-1:0]           trip_vec;
   logic [OC_SRC_N-1:0]        oc_hit;
   logic [OC_SRC_N-1:0]        oc_trip;
   logic [OC_SEL_W-1:0]        oc_sel [OC_SRC_N];
   logic                       uv_trip;

   always_comb begin
      armed     = !pfc_stop;
      oc_hit[0] = pfc_oc_hit;
      oc_hit[1] = llc_oc_hit;
      oc_sel[0] = pfc_oc_limit_sel;
      oc_sel[1] = llc_oc_limit_sel;
   end

   generate
      for (genvar s = 0; s < OC_SRC_N; s++) begin : g_oc
         fm_event_counter #(.MAX_LOG(OC_MAX_LOG)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (armed),
            .en         (fault_en[FI_PFC_OC + s]),
            .hit        (oc_hit[s]),
            .cycle_done (sw_cycle_done),
            .limit_sel  (oc_sel[s]),
            .trip       (oc_trip[s])
         );
      end
   endgenerate

   fm_uv_qualifier #(.PERSIST_CYC(UV_PERSIST_CYC)) u_uv (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (armed),
      .en       (fault_en[FI_UV]),
      .uv       (bus_uv_lvl),
      .brownout (brownout_lvl),
      .adaptive (uv_adaptive),
      .trip     (uv_trip)
   );

   always_comb begin
      trip_vec             = '0;
      trip_vec[FI_PFC_OC]  = oc_trip[0];
      trip_vec[FI_LLC_OC]  = oc_trip[1];
      trip_vec[FI_PFC_OVP] = armed && fault_en[FI_PFC_OVP] && pfc_ovp_hit;
      trip_vec[FI_LLC_OVP] = armed && fault_en[FI_LLC_OVP] && llc_ovp_hit;
      trip_vec[FI_UV]      = uv_trip;
      trip_vec[FI_FB_OPEN] = armed && fault_en[FI_FB_OPEN] && fb_open_hit;
      trip_vec[FI_SS_TO]   = armed && fault_en[FI_SS_TO] && ss_timeout_hit;
   end

   fm_shutdown_seq #(
      .EW_LONG_CYC    (EW_LONG_CYC),
      .EW_SHORT_CYC   (EW_SHORT_CYC),
      .RETRY_BASE_CYC (RETRY_BASE_CYC),
      .RETRY_SEL_W    (2)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .trip_vec    (trip_vec),
      .latch_sel   (fault_latch_sel),
      .retry_sel   (retry_sel),
      .burst_quick (burst_quick),
      .pfc_stop    (pfc_stop),
      .llc_stop    (llc_stop),
      .latched     (latched),
      .restart_req (restart_req),
      .ew_pulse    (ew_pulse)
   );

   assert_llc_never_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      llc_stop |-> pfc_stop);

   assert_stopped_ignores_R13: assert property (@(posedge clk) disable iff (!rst_n)
      pfc_stop |-> (trip_vec == '0));
endmodule

// File: tb/fm_fault_manager_bench.sv
`timescale 1ns/1ps
module fm_fault_manager_bench;
   localparam int CPU   = 1;
   localparam int LONG  = 40;
   localparam int SHORT = 12;
   localparam int PERS  = 25;
   localparam int RBASE = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_cycle_done = 0, pfc_oc_hit = 0, llc_oc_hit = 0, pfc_ovp_hit = 0;
   logic llc_ovp_hit = 0, fb_open_hit = 0, ss_timeout_hit = 0;
   logic bus_uv_lvl = 0, brownout_lvl = 0, uv_adaptive = 0, burst_quick = 0;
   logic [6:0] fault_en = 7'h7F;
   logic [6:0] fault_latch_sel = 7'h00;
   logic [1:0] pfc_oc_limit_sel = 0, llc_oc_limit_sel = 0, retry_sel = 0;
   logic pfc_stop, llc_stop, latched, restart_req, ew_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   fm_fault_manager #(
      .CYC_PER_US(CPU), .EW_LONG_US(LONG), .EW_SHORT_US(SHORT),
      .UV_PERSIST_US(PERS), .RETRY_BASE_US(RBASE), .OC_MAX_LOG(3)
   ) u_fm_fault_manager (
      .clk(clk), .rst_n(rst_n), .sw_cycle_done(sw_cycle_done),
      .pfc_oc_hit(pfc_oc_hit), .llc_oc_hit(llc_oc_hit), .pfc_ovp_hit(pfc_ovp_hit),
      .llc_ovp_hit(llc_ovp_hit), .fb_open_hit(fb_open_hit), .ss_timeout_hit(ss_timeout_hit),
      .bus_uv_lvl(bus_uv_lvl), .brownout_lvl(brownout_lvl), .fault_en(fault_en),
      .fault_latch_sel(fault_latch_sel), .pfc_oc_limit_sel(pfc_oc_limit_sel),
      .llc_oc_limit_sel(llc_oc_limit_sel), .uv_adaptive(uv_adaptive), .retry_sel(retry_sel),
      .burst_quick(burst_quick), .pfc_stop(pfc_stop), .llc_stop(llc_stop),
      .latched(latched), .restart_req(restart_req), .ew_pulse(ew_pulse)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // source index: 0..6 as the fault_en positions, -1 = none
   task automatic hit(input int k, input bit done);
      pfc_oc_hit     = (k == 0);
      llc_oc_hit     = (k == 1);
      pfc_ovp_hit    = (k == 2);
      llc_ovp_hit    = (k == 3);
      fb_open_hit    = (k == 5);
      ss_timeout_hit = (k == 6);
      sw_cycle_done  = done;
      @(negedge clk);
      pfc_oc_hit = 0; llc_oc_hit = 0; pfc_ovp_hit = 0; llc_ovp_hit = 0;
      fb_open_hit = 0; ss_timeout_hit = 0; sw_cycle_done = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   // called at the first negedge after the tripping edge
   task automatic observe(input string tag, input int exp_len, input bit exp_llc,
                          input bit exp_lock, input int exp_retry);
      int w;
      int r;
      bit saw_restart;
      w = 0;
      chk({tag, " R8/R9 llc_stop during pulse"}, llc_stop, exp_llc);
      while (ew_pulse && w < 1000) begin
         w++;
         @(negedge clk);
      end
      chk({tag, " R8/R9 pulse length"}, w, exp_len);
      chk({tag, " R8 llc_stop after pulse"}, llc_stop, 1);
      if (exp_lock) begin
         chk({tag, " R11 latched"}, latched, 1);
         saw_restart = 0;
         for (int i = 0; i < 3 * RBASE * 8; i++) begin
            if (restart_req || !pfc_stop || !latched) saw_restart = 1;
            @(negedge clk);
         end
         chk({tag, " R11 held until reset"}, saw_restart, 0);
         do_reset();
      end else begin
         chk({tag, " R11 not latched"}, latched, 0);
         r = 0;
         while (pfc_stop && r < 5000) begin
            r++;
            @(negedge clk);
         end
         chk({tag, " R12 retry length"}, r, exp_retry);
         chk({tag, " R12 restart_req"}, restart_req, 1);
         chk({tag, " R12 llc released"}, llc_stop, 0);
         @(negedge clk);
         chk({tag, " R12 restart one cycle"}, restart_req, 0);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      int any_stop;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 pfc_stop", pfc_stop, 0);
      chk("R1 llc_stop", llc_stop, 0);
      chk("R1 latched", latched, 0);
      chk("R1 restart_req", restart_req, 0);
      chk("R1 ew_pulse", ew_pulse, 0);

      // R2 sweep: both sources, every run-length code, retry code follows
      for (int src = 0; src < 2; src++) begin
         for (int sel = 0; sel < 4; sel++) begin
            pfc_oc_limit_sel = sel[1:0];
            llc_oc_limit_sel = sel[1:0];
            retry_sel = sel[1:0];
            for (int i = 0; i < (1 << sel) - 1; i++) begin
               hit(src, 0);
               idle(1);
            end
            chk($sformatf("R2 src%0d code%0d below limit", src, sel), pfc_stop, 0);
            hit(src, 0);
            chk($sformatf("R2 src%0d code%0d trips", src, sel), pfc_stop, 1);
            observe($sformatf("oc src%0d code%0d", src, sel), SHORT, 1, 0, RBASE << sel);
         end
      end
      retry_sel = 0;

      // R3: a quiet completed cycle clears; an event with completion counts
      pfc_oc_limit_sel = 2;
      hit(0, 0); hit(0, 0); hit(0, 0);
      hit(-1, 1);
      hit(0, 0); hit(0, 0); hit(0, 0);
      chk("R3 quiet cycle cleared count", pfc_stop, 0);
      hit(-1, 1);
      hit(0, 1); hit(0, 1); hit(0, 1);
      chk("R3 three coincident events no trip", pfc_stop, 0);
      hit(0, 0);
      chk("R3 coincident events counted", pfc_stop, 1);
      observe("R3 trip", SHORT, 1, 0, RBASE);

      // R4 immediate sources; feedback-open latches with its bit clear (R11)
      for (int k = 2; k < 7; k++) begin
         if (k == 4) continue;
         hit(k, 0);
         chk($sformatf("R4 src%0d pfc_stop", k), pfc_stop, 1);
         chk($sformatf("R4 src%0d llc_stop", k), llc_stop, 1);
         observe($sformatf("imm src%0d", k), SHORT, 1, (k == 5), RBASE);
      end
      fault_latch_sel = 7'b1000000;
      hit(6, 0);
      observe("R11 timeout latched", SHORT, 1, 1, RBASE);
      fault_latch_sel = 7'h00;

      // R13: a feedback-open strobe during the pulse is ignored
      hit(2, 0);
      hit(5, 0);
      observe("R13 strobe while stopped", SHORT - 1, 1, 0, RBASE);

      // R5: everything disabled
      fault_en = 7'h00;
      uv_adaptive = 1; bus_uv_lvl = 1; brownout_lvl = 1;
      any_stop = 0;
      for (int k = 0; k < 7; k++) begin
         hit(k, 0);
         if (pfc_stop) any_stop = 1;
      end
      idle(PERS + 5);
      if (pfc_stop) any_stop = 1;
      chk("R5 disabled sources ignored", any_stop, 0);
      bus_uv_lvl = 0; brownout_lvl = 0; uv_adaptive = 0;
      fault_en = 7'h7F;
      idle(1);

      // R6 slow undervoltage with a dropout
      bus_uv_lvl = 1;
      idle(PERS - 1);
      chk("R6 one short of window", pfc_stop, 0);
      bus_uv_lvl = 0;
      idle(1);
      bus_uv_lvl = 1;
      idle(PERS - 1);
      chk("R6 dropout restarted window", pfc_stop, 0);
      idle(1);
      chk("R6 trips at window", pfc_stop, 1);
      bus_uv_lvl = 0;
      observe("R8 slow uv", LONG, 0, 0, RBASE);

      // R7 adaptive with and without brown-out; brown-out alone in slow mode
      brownout_lvl = 1;
      bus_uv_lvl = 1;
      idle(1);
      chk("R7 slow mode ignores brown-out", pfc_stop, 0);
      bus_uv_lvl = 0;
      idle(1);
      uv_adaptive = 1;
      bus_uv_lvl = 1;
      idle(1);
      chk("R7 adaptive immediate", pfc_stop, 1);
      bus_uv_lvl = 0; brownout_lvl = 0;
      observe("R7 adaptive", LONG, 0, 0, RBASE);
      bus_uv_lvl = 1;
      idle(PERS - 1);
      chk("R7 adaptive without brown-out waits", pfc_stop, 0);
      idle(1);
      chk("R7 adaptive falls back to window", pfc_stop, 1);
      bus_uv_lvl = 0;
      observe("R7 fallback", LONG, 0, 0, RBASE);

      // R10 burst flag forces the short pulse
      burst_quick = 1;
      bus_uv_lvl = 1; brownout_lvl = 1;
      idle(1);
      chk("R10 burst uv trips", pfc_stop, 1);
      bus_uv_lvl = 0; brownout_lvl = 0;
      observe("R10 burst", SHORT, 1, 0, RBASE);
      burst_quick = 0;

      // R9 benign and dangerous in the same cycle
      bus_uv_lvl = 1; brownout_lvl = 1;
      hit(6, 0);
      chk("R9 coincident trip", pfc_stop, 1);
      bus_uv_lvl = 0; brownout_lvl = 0;
      observe("R9 coincident", SHORT, 1, 0, RBASE);

      summary();
      $finish;
   end
endmodule